// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block sits between instruction fetch and the execution units of a small two-slot processor core. It takes one 32-bit instruction word per step. A two-bit format field tells it how to split the word. The word is either one long operation or two 15-bit short operations. A pair of shorts runs one after the other in a stated order, or as a parallel pair in which one slot may be a condition test that decides whether the other slot runs. The operations go out on per-slot issue strobes. The execution side answers in the same cycle with a PC-changed flag, a branch target and a condition flag.

Once every operation of the word has issued, the sequencer commits the next program counter. It applies the hardware repeat loop: at the loop-end address it either jumps back to the loop start or, on the last pass, leaves the loop and turns repeat mode off. It then checks the instruction-address breakpoint. A breakpoint hit overrides any branch or loop outcome and sends the core to a fixed trap vector. The sequencer produces strobes with data so that the surrounding register file can update the repeat counter, the status word and the two backup registers the trap fills.

Top module: `issue_seq`

## Requirements
- R1: A word whose bits 31:30 are 11 issues one long operation: `go_long` is high for one cycle with `long_op` equal to bits 29:0, and neither short strobe is high in that cycle.
- R2: Format 01 issues the left short (bits 29:15 on `left_op`) in the first issue cycle and the right short (bits 14:0 on `right_op`) in the next cycle. The two never share a cycle.
- R3: Format 10 issues the right short in the first issue cycle and the left short in the next cycle.
- R4: In formats 01 and 10, if the first short reports a PC change, the second short is not issued. The committed PC is then the reported target.
- R5: Format 00 with neither slot marked test-only issues both shorts in the same single cycle.
- R6: Format 00 with the left slot marked test-only issues the left slot, and the right slot only when `exe_cond_true` is high. With only the right slot marked test-only, the roles swap. When both slots are marked, the left slot is the test.
- R7: If no operation changed the PC, repeat mode (status bit `RP_BIT`, default 1) is set, the current PC equals `rpt_end` and `rpt_cnt_in` is 1, then the sequencer writes 0 to the counter, writes the status word with `RP_BIT` cleared, and advances the PC by 1.
- R8: Under the same loop-end conditions with any other count, the sequencer writes the count minus 1 and loads the PC with `rpt_start`. The status word is not written.
- R9: If no operation changed the PC and no loop-end applies, the PC advances by 1 (modulo 2^PC_W). `fetch_addr` always equals the PC times 4.
- R10: If debug enable (status bit `DB_BIT`, default 2) is set and the PC chosen by R4/R7/R8/R9 equals `bp_addr`, the trap fires. `bpc_val` takes that PC and `bpsw_val` takes `psw_in`. The status word is written with only bit `SM_BIT` (default 15) kept, and the PC becomes `TRAP_VEC` (default 0x0F00). This overrides any branch or loop outcome.
- R11: After reset the PC is `PC_RESET` (default 0), `ready` is high and every strobe is low. A step is accepted only while `ready` is high. `done` pulses for exactly one cycle when the new PC appears, and the counter, status and trap strobes pulse only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | Start a step with the word on `insn_word` |
| insn_word | input | 32 | Fetched instruction word |
| left_test_only | input | 1 | Decoder flag: left short is a condition-test-only operation |
| right_test_only | input | 1 | Decoder flag: right short is a condition-test-only operation |
| ready | output | 1 | Sequencer idle, able to accept a step |
| go_long | output | 1 | Issue strobe for the long operation |
| go_left | output | 1 | Issue strobe for the left short |
| go_right | output | 1 | Issue strobe for the right short |
| long_op | output | 30 | Long operation payload |
| left_op | output | 15 | Left short payload |
| right_op | output | 15 | Right short payload |
| exe_pc_chg | input | 1 | An issued operation changed the PC this cycle |
| exe_new_pc | input | PC_W | Branch target when `exe_pc_chg` is high |
| exe_cond_true | input | 1 | Condition flag produced by a test-only operation |
| psw_in | input | PSW_W | Current status word |
| rpt_start | input | PC_W | Repeat loop start address |
| rpt_end | input | PC_W | Repeat loop end address |
| rpt_cnt_in | input | CNT_W | Current repeat count |
| bp_addr | input | PC_W | Instruction breakpoint address |
| pc | output | PC_W | Program counter, in 32-bit words |
| fetch_addr | output | PC_W+2 | Byte fetch address of `pc` |
| done | output | 1 | One-cycle pulse when the next PC is committed |
| rpt_cnt_wr | output | 1 | Write strobe for the repeat counter |
| rpt_cnt_nxt | output | CNT_W | New repeat count |
| psw_wr | output | 1 | Write strobe for the status word |
| psw_nxt | output | PSW_W | New status word |
| trap_save | output | 1 | Write strobe for both backup registers |
| bpc_val | output | PC_W | PC saved by the breakpoint trap |
| bpsw_val | output | PSW_W | Status word saved by the breakpoint trap |

## Verification
On every cycle the assertions check a set of invariants. A long issue never shares a cycle with a short. No strobe appears while the sequencer is idle. `done` is a single-cycle pulse, and the counter strobe only appears with it. A trap always lands on the vector with the status word reduced to the stack-mode bit. A loop-end commit either jumps to the loop start or steps past the loop with repeat mode cleared. Some properties depend on the order and content of a step, and only the bench scenarios can show them. These are the exact issue order of each format, the suppression of the second short after a taken branch, predication in a parallel pair as the condition flag varies, and the precedence of the trap over a branch or loop exit.

// File: rtl/issue_seq_pkg.sv
// Shared format codes, sequencer states and slot widths of the issue sequencer.
// Assumes the fixed 32-bit word layout: format in 31:30, shorts in 29:15 / 14:0.
package issue_seq_pkg;
    localparam int WORD_W  = 32;
    localparam int SHORT_W = 15;
    localparam int LONG_W  = 30;

    typedef enum logic [1:0] {
        FMT_PAR  = 2'b00,
        FMT_LR   = 2'b01,
        FMT_RL   = 2'b10,
        FMT_LONG = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_COMMIT
    } st_e;
endpackage

// File: rtl/issue_seq_split.sv
// Slices a held instruction word into its format code and slot payloads.
// Purely combinational; assumes the word layout defined in issue_seq_pkg.
module issue_seq_split
    import issue_seq_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    output fmt_e               fmt,
    output logic [SHORT_W-1:0] left_fld,
    output logic [SHORT_W-1:0] right_fld,
    output logic [LONG_W-1:0]  long_fld
);
    assign fmt       = fmt_e'(word[WORD_W-1 -: 2]);
    assign left_fld  = word[2*SHORT_W-1 : SHORT_W];
    assign right_fld = word[SHORT_W-1 : 0];
    assign long_fld  = word[LONG_W-1 : 0];
endmodule

// File: rtl/issue_seq_ctrl.sv
// Step controller: latches a word, drives the slot strobes over one or two
// issue cycles and records whether an issued operation redirected the PC.
// Assumes the execution side answers combinationally in the issue cycle.
module issue_seq_ctrl
    import issue_seq_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_valid,
    input  logic [WORD_W-1:0]  insn_word,
    input  logic               left_test_only,
    input  logic               right_test_only,
    input  logic               exe_pc_chg,
    input  logic [PC_W-1:0]    exe_new_pc,
    input  logic               exe_cond_true,
    output logic               ready,
    output logic               go_long,
    output logic               go_left,
    output logic               go_right,
    output logic [LONG_W-1:0]  long_op,
    output logic [SHORT_W-1:0] left_op,
    output logic [SHORT_W-1:0] right_op,
    output logic               commit,
    output logic               chg_q,
    output logic [PC_W-1:0]    tgt_q
);
    st_e               st;
    logic [WORD_W-1:0] word_q;
    logic              lt_q, rt_q;
    fmt_e              fmt;
    logic              is_seq;

    issue_seq_split u_split (
        .word      (word_q),
        .fmt       (fmt),
        .left_fld  (left_op),
        .right_fld (right_op),
        .long_fld  (long_op)
    );

    assign is_seq = (fmt == FMT_LR) || (fmt == FMT_RL);
    assign ready  = (st == ST_IDLE);
    assign commit = (st == ST_COMMIT);

    // State progression and capture of the execution answer per issue cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            word_q <= '0;
            lt_q   <= 1'b0;
            rt_q   <= 1'b0;
            chg_q  <= 1'b0;
            tgt_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (step_valid) begin
                    word_q <= insn_word;
                    lt_q   <= left_test_only;
                    rt_q   <= right_test_only;
                    chg_q  <= 1'b0;
                    st     <= ST_FIRST;
                end
                ST_FIRST: begin
                    chg_q <= exe_pc_chg;
                    tgt_q <= exe_new_pc;
                    st    <= (is_seq && !exe_pc_chg) ? ST_SECOND : ST_COMMIT;
                end
                ST_SECOND: begin
                    chg_q <= exe_pc_chg;
                    tgt_q <= exe_new_pc;
                    st    <= ST_COMMIT;
                end
                ST_COMMIT: st <= ST_IDLE;
            endcase
        end
    end

    // Slot strobes for the current issue cycle, predication included.
    always_comb begin
        go_long  = 1'b0;
        go_left  = 1'b0;
        go_right = 1'b0;
        if (st == ST_FIRST) begin
            unique case (fmt)
                FMT_LONG: go_long  = 1'b1;
                FMT_LR:   go_left  = 1'b1;
                FMT_RL:   go_right = 1'b1;
                FMT_PAR: begin
                    if (lt_q) begin
                        go_left  = 1'b1;
                        go_right = exe_cond_true;
                    end else if (rt_q) begin
                        go_right = 1'b1;
                        go_left  = exe_cond_true;
                    end else begin
                        go_left  = 1'b1;
                        go_right = 1'b1;
                    end
                end
            endcase
        end else if (st == ST_SECOND) begin
            go_right = (fmt == FMT_LR);
            go_left  = (fmt == FMT_RL);
        end
    end
endmodule

// File: rtl/issue_seq_npc.sv
// Next-PC selection: branch target, repeat loop and breakpoint trap, plus
// the register updates those imply. Combinational; evaluated in the commit cycle.
module issue_seq_npc #(
    parameter int          PC_W     = 16,
    parameter int          CNT_W    = 16,
    parameter int          PSW_W    = 16,
    parameter int          RP_BIT   = 1,
    parameter int          DB_BIT   = 2,
    parameter int          SM_BIT   = 15,
    parameter int unsigned TRAP_VEC = 'h0F00
) (
    input  logic [PC_W-1:0]  pc_cur,
    input  logic             chg,
    input  logic [PC_W-1:0]  tgt,
    input  logic [PSW_W-1:0] psw_in,
    input  logic [PC_W-1:0]  rpt_start,
    input  logic [PC_W-1:0]  rpt_end,
    input  logic [CNT_W-1:0] rpt_cnt_in,
    input  logic [PC_W-1:0]  bp_addr,
    output logic [PC_W-1:0]  pc_nxt,
    output logic             cnt_wr,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             psw_wr,
    output logic [PSW_W-1:0] psw_nxt,
    output logic             trap,
    output logic [PC_W-1:0]  bpc,
    output logic [PSW_W-1:0] bpsw
);
    localparam logic [PSW_W-1:0] SM_MASK = PSW_W'(1) << SM_BIT;
    localparam logic [PSW_W-1:0] RP_MASK = PSW_W'(1) << RP_BIT;

    logic            loop_hit, last_pass;
    logic [PC_W-1:0] flow_pc;

    // Flow PC before the breakpoint check.
    always_comb begin
        loop_hit  = !chg && psw_in[RP_BIT] && (pc_cur == rpt_end);
        last_pass = (rpt_cnt_in == CNT_W'(1));
        if (chg)                       flow_pc = tgt;
        else if (loop_hit && !last_pass) flow_pc = rpt_start;
        else                           flow_pc = pc_cur + PC_W'(1);
    end

    // Breakpoint override and the register writes of this commit.
    always_comb begin
        trap    = psw_in[DB_BIT] && (flow_pc == bp_addr);
        pc_nxt  = trap ? PC_W'(TRAP_VEC) : flow_pc;
        cnt_wr  = loop_hit;
        cnt_nxt = last_pass ? '0 : rpt_cnt_in - CNT_W'(1);
        psw_wr  = trap || (loop_hit && last_pass);
        psw_nxt = trap ? (psw_in & SM_MASK) : (psw_in & ~RP_MASK);
        bpc     = flow_pc;
        bpsw    = psw_in;
    end
endmodule

// File: rtl/issue_seq.sv
// Top of the dual-slot issue sequencer: step controller, next-PC logic and
// the committed PC with its one-cycle update strobes.
module issue_seq
    import issue_seq_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter int          CNT_W    = 16,
    parameter int          PSW_W    = 16,
    parameter int          RP_BIT   = 1,
    parameter int          DB_BIT   = 2,
    parameter int          SM_BIT   = 15,
    parameter int unsigned TRAP_VEC = 'h0F00,
    parameter int unsigned PC_RESET = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_valid,
    input  logic [31:0]        insn_word,
    input  logic               left_test_only,
    input  logic               right_test_only,
    output logic               ready,
    output logic               go_long,
    output logic               go_left,
    output logic               go_right,
    output logic [29:0]        long_op,
    output logic [14:0]        left_op,
    output logic [14:0]        right_op,
    input  logic               exe_pc_chg,
    input  logic [PC_W-1:0]    exe_new_pc,
    input  logic               exe_cond_true,
    input  logic [PSW_W-1:0]   psw_in,
    input  logic [PC_W-1:0]    rpt_start,
    input  logic [PC_W-1:0]    rpt_end,
    input  logic [CNT_W-1:0]   rpt_cnt_in,
    input  logic [PC_W-1:0]    bp_addr,
    output logic [PC_W-1:0]    pc,
    output logic [PC_W+1:0]    fetch_addr,
    output logic               done,
    output logic               rpt_cnt_wr,
    output logic [CNT_W-1:0]   rpt_cnt_nxt,
    output logic               psw_wr,
    output logic [PSW_W-1:0]   psw_nxt,
    output logic               trap_save,
    output logic [PC_W-1:0]    bpc_val,
    output logic [PSW_W-1:0]   bpsw_val
);
    logic             commit, chg_q;
    logic [PC_W-1:0]  tgt_q, pc_q, n_pc, n_bpc;
    logic             n_cnt_wr, n_psw_wr, n_trap;
    logic [CNT_W-1:0] n_cnt;
    logic [PSW_W-1:0] n_psw, n_bpsw;

    issue_seq_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .step_valid      (step_valid),
        .insn_word       (insn_word),
        .left_test_only  (left_test_only),
        .right_test_only (right_test_only),
        .exe_pc_chg      (exe_pc_chg),
        .exe_new_pc      (exe_new_pc),
        .exe_cond_true   (exe_cond_true),
        .ready           (ready),
        .go_long         (go_long),
        .go_left         (go_left),
        .go_right        (go_right),
        .long_op         (long_op),
        .left_op         (left_op),
        .right_op        (right_op),
        .commit          (commit),
        .chg_q           (chg_q),
        .tgt_q           (tgt_q)
    );

    issue_seq_npc #(
        .PC_W(PC_W), .CNT_W(CNT_W), .PSW_W(PSW_W), .RP_BIT(RP_BIT),
        .DB_BIT(DB_BIT), .SM_BIT(SM_BIT), .TRAP_VEC(TRAP_VEC)
    ) u_npc (
        .pc_cur     (pc_q),
        .chg        (chg_q),
        .tgt        (tgt_q),
        .psw_in     (psw_in),
        .rpt_start  (rpt_start),
        .rpt_end    (rpt_end),
        .rpt_cnt_in (rpt_cnt_in),
        .bp_addr    (bp_addr),
        .pc_nxt     (n_pc),
        .cnt_wr     (n_cnt_wr),
        .cnt_nxt    (n_cnt),
        .psw_wr     (n_psw_wr),
        .psw_nxt    (n_psw),
        .trap       (n_trap),
        .bpc        (n_bpc),
        .bpsw       (n_bpsw)
    );

    // Commit the PC and emit the update strobes aligned with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= PC_W'(PC_RESET);
            done        <= 1'b0;
            rpt_cnt_wr  <= 1'b0;
            psw_wr      <= 1'b0;
            trap_save   <= 1'b0;
            rpt_cnt_nxt <= '0;
            psw_nxt     <= '0;
            bpc_val     <= '0;
            bpsw_val    <= '0;
        end else begin
            done       <= commit;
            rpt_cnt_wr <= commit && n_cnt_wr;
            psw_wr     <= commit && n_psw_wr;
            trap_save  <= commit && n_trap;
            if (commit) begin
                pc_q        <= n_pc;
                rpt_cnt_nxt <= n_cnt;
                psw_nxt     <= n_psw;
                bpc_val     <= n_bpc;
                bpsw_val    <= n_bpsw;
            end
        end
    end

    assign pc         = pc_q;
    assign fetch_addr = {pc_q, 2'b00};
endmodule

// File: rtl/issue_seq_chk.sv
// Cycle invariants of the issue sequencer, bound onto every issue_seq instance.
// Assumes the loop registers are stable between the commit and done cycles.
module issue_seq_chk #(
    parameter int          PC_W     = 16,
    parameter int          CNT_W    = 16,
    parameter int          PSW_W    = 16,
    parameter int          RP_BIT   = 1,
    parameter int          SM_BIT   = 15,
    parameter int unsigned TRAP_VEC = 'h0F00
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             go_long,
    input logic             go_left,
    input logic             go_right,
    input logic             done,
    input logic [PC_W-1:0]  pc,
    input logic [PC_W-1:0]  rpt_start,
    input logic             rpt_cnt_wr,
    input logic [CNT_W-1:0] rpt_cnt_nxt,
    input logic             psw_wr,
    input logic [PSW_W-1:0] psw_nxt,
    input logic             trap_save,
    input logic [PSW_W-1:0] bpsw_val
);
    localparam logic [PSW_W-1:0] SM_MASK = PSW_W'(1) << SM_BIT;

    assert_long_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
        go_long |-> (!go_left && !go_right));

    assert_no_issue_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (go_long || go_left || go_right) |-> !ready);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cnt_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_cnt_wr || psw_wr || trap_save) |-> done);

    assert_trap_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_save |-> (pc == PC_W'(TRAP_VEC) && psw_wr && psw_nxt == (bpsw_val & SM_MASK)));

    assert_loop_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_cnt_wr && rpt_cnt_nxt != '0 && !trap_save) |-> (pc == $past(rpt_start) && !psw_wr));

    assert_loop_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_cnt_wr && rpt_cnt_nxt == '0 && !trap_save) |->
        (psw_wr && !psw_nxt[RP_BIT] && pc == PC_W'($past(pc) + 1'b1)));
endmodule

bind issue_seq issue_seq_chk #(
    .PC_W(PC_W), .CNT_W(CNT_W), .PSW_W(PSW_W), .RP_BIT(RP_BIT),
    .SM_BIT(SM_BIT), .TRAP_VEC(TRAP_VEC)
) u_issue_seq_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .go_long(go_long), .go_left(go_left),
    .go_right(go_right), .done(done), .pc(pc), .rpt_start(rpt_start),
    .rpt_cnt_wr(rpt_cnt_wr), .rpt_cnt_nxt(rpt_cnt_nxt), .psw_wr(psw_wr),
    .psw_nxt(psw_nxt), .trap_save(trap_save), .bpsw_val(bpsw_val)
);

// File: tb/test_issue_seq.sv
// Bench for issue_seq: directed corner steps then seeded random steps,
// each compared against a model derived from the requirements.
module test_issue_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RPB = 1, DBB = 2, SMB = 15;
    localparam logic [15:0] VEC = 16'h0F00;

    logic clk = 1'b0, rst_n = 1'b0;
    logic step_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic lt = 1'b0, rt = 1'b0;
    logic ready, go_long, go_left, go_right;
    logic [29:0] long_op;
    logic [14:0] left_op, right_op;
    logic exe_pc_chg, exe_cond_true;
    logic [15:0] exe_new_pc;
    logic [15:0] psw_in = '0, rpt_start = '0, rpt_end = '0, rpt_cnt_in = '0, bp_addr = '0;
    logic [15:0] pc, rpt_cnt_nxt, psw_nxt, bpc_val, bpsw_val;
    logic [17:0] fetch_addr;
    logic done, rpt_cnt_wr, psw_wr, trap_save;

    // Execution-side model: per-slot branch flags, shared target and flag.
    logic cl = 1'b0, cr = 1'b0, cg = 1'b0, cond_v = 1'b0;
    logic [15:0] tgt = '0;
    assign exe_pc_chg    = (go_long & cg) | (go_left & cl) | (go_right & cr);
    assign exe_cond_true = cond_v;
    assign exe_new_pc    = tgt;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_pc = '0;

    issue_seq i_issue_seq (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .insn_word(insn_word),
        .left_test_only(lt), .right_test_only(rt), .ready(ready),
        .go_long(go_long), .go_left(go_left), .go_right(go_right),
        .long_op(long_op), .left_op(left_op), .right_op(right_op),
        .exe_pc_chg(exe_pc_chg), .exe_new_pc(exe_new_pc), .exe_cond_true(exe_cond_true),
        .psw_in(psw_in), .rpt_start(rpt_start), .rpt_end(rpt_end),
        .rpt_cnt_in(rpt_cnt_in), .bp_addr(bp_addr), .pc(pc), .fetch_addr(fetch_addr),
        .done(done), .rpt_cnt_wr(rpt_cnt_wr), .rpt_cnt_nxt(rpt_cnt_nxt),
        .psw_wr(psw_wr), .psw_nxt(psw_nxt), .trap_save(trap_save),
        .bpc_val(bpc_val), .bpsw_val(bpsw_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Run one step and compare every output against the requirement model.
    task automatic run(input logic [1:0] fmt, input logic [14:0] lf, input logic [14:0] rf,
                       input logic [29:0] lg, input logic tl, input logic tr, input logic cv,
                       input logic bl, input logic br, input logic bg, input logic [15:0] tg,
                       input logic [15:0] psw, input logic [15:0] rs, input logic [15:0] re,
                       input logic [15:0] cnt, input logic [15:0] bp);
        logic [31:0] w;
        logic [2:0] s0, s1;
        logic [5:0] got;
        int e_n, n;
        logic chg, loop, last, trap, pay_ok, seen;
        logic [15:0] flow, e_pc;
        string sreq, preq;
        w = (fmt == 2'b11) ? {2'b11, lg} : {fmt, lf, rf};
        s1 = 3'b000; e_n = 1; chg = 1'b0;
        // Expected issue order per format (bits: long, left, right).
        case (fmt)
            2'b11: begin s0 = 3'b100; chg = bg; sreq = "R1"; end
            2'b01: begin s0 = 3'b010; sreq = "R2";
                if (bl) begin chg = 1'b1; sreq = "R4"; end
                else begin s1 = 3'b001; e_n = 2; chg = br; end
            end
            2'b10: begin s0 = 3'b001; sreq = "R3";
                if (br) begin chg = 1'b1; sreq = "R4"; end
                else begin s1 = 3'b010; e_n = 2; chg = bl; end
            end
            default: begin
                if (tl)      begin s0 = {2'b01, cv}; sreq = "R6"; end
                else if (tr) begin s0 = {1'b0, cv, 1'b1}; sreq = "R6"; end
                else         begin s0 = 3'b011; sreq = "R5"; end
                chg = (s0[1] & bl) | (s0[0] & br);
            end
        endcase
        loop = !chg && psw[RPB] && (exp_pc == re);
        last = (cnt == 16'd1);
        flow = chg ? tg : (loop && !last) ? rs : exp_pc + 16'd1;
        trap = psw[DBB] && (flow == bp);
        e_pc = trap ? VEC : flow;
        preq = trap ? "R10" : (loop && last) ? "R7" : loop ? "R8" : chg ? "R4" : "R9";

        @(negedge clk);
        check(ready === 1'b1, "R11", "ready before step", {31'd0, ready}, 32'd1);
        insn_word = w; lt = tl; rt = tr; cond_v = cv; cl = bl; cr = br; cg = bg; tgt = tg;
        psw_in = psw; rpt_start = rs; rpt_end = re; rpt_cnt_in = cnt; bp_addr = bp;
        step_valid = 1'b1;
        @(negedge clk);
        step_valid = 1'b0;
        n = 0; got = '0; pay_ok = 1'b1; seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (done) begin seen = 1'b1; break; end
            if (go_long | go_left | go_right) begin
                if (n == 0) got[5:3] = {go_long, go_left, go_right};
                else        got[2:0] = {go_long, go_left, go_right};
                n++;
                if (go_long  && long_op  !== w[29:0])  pay_ok = 1'b0;
                if (go_left  && left_op  !== w[29:15]) pay_ok = 1'b0;
                if (go_right && right_op !== w[14:0])  pay_ok = 1'b0;
            end
            @(negedge clk);
        end
        check(seen, "R11", "done pulse", {31'd0, seen}, 32'd1);
        check(got == {s0, s1}, sreq, "issue order", {26'd0, got}, {26'd0, s0, s1});
        check(n == e_n, sreq, "issue cycles", n, e_n);
        check(pay_ok, sreq, "slot payload", {31'd0, pay_ok}, 32'd1);
        check(pc == e_pc, preq, "next pc", {16'd0, pc}, {16'd0, e_pc});
        check(fetch_addr == {e_pc, 2'b00}, "R9", "fetch addr", {14'd0, fetch_addr}, {14'd0, e_pc, 2'b00});
        check(rpt_cnt_wr == loop, loop ? (last ? "R7" : "R8") : "R9", "count write",
              {31'd0, rpt_cnt_wr}, {31'd0, loop});
        if (loop)
            check(rpt_cnt_nxt == (last ? 16'd0 : cnt - 16'd1), last ? "R7" : "R8", "count value",
                  {16'd0, rpt_cnt_nxt}, {16'd0, last ? 16'd0 : cnt - 16'd1});
        check(psw_wr == (trap || (loop && last)), trap ? "R10" : "R7", "status write",
              {31'd0, psw_wr}, {31'd0, trap || (loop && last)});
        if (trap)
            check(psw_nxt == (psw & 16'h8000), "R10", "trap status", {16'd0, psw_nxt}, {16'd0, psw & 16'h8000});
        else if (loop && last)
            check(psw_nxt == (psw & ~16'h0002), "R7", "loop exit status", {16'd0, psw_nxt}, {16'd0, psw & ~16'h0002});
        check(trap_save == trap, "R10", "trap strobe", {31'd0, trap_save}, {31'd0, trap});
        if (trap) begin
            check(bpc_val == flow, "R10", "saved pc", {16'd0, bpc_val}, {16'd0, flow});
            check(bpsw_val == psw, "R10", "saved status", {16'd0, bpsw_val}, {16'd0, psw});
        end
        exp_pc = e_pc;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2C_3B4A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pc == 16'd0 && fetch_addr == 18'd0, "R11", "reset pc", {16'd0, pc}, 32'd0);
        check(!done && !rpt_cnt_wr && !psw_wr && !trap_save, "R11", "reset strobes",
              {28'd0, done, rpt_cnt_wr, psw_wr, trap_save}, 32'd0);
        check(ready && !go_long && !go_left && !go_right, "R11", "reset idle",
              {28'd0, ready, go_long, go_left, go_right}, 32'h8);
        // Directed: formats, branch suppression, predication.
        run(2'b11, 15'h0, 15'h0, 30'h2ABC_1234, 0,0,0, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b01, 15'h1234, 15'h4321, 0, 0,0,0, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b10, 15'h7001, 15'h0FFE, 0, 0,0,0, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b01, 15'h1111, 15'h2222, 0, 0,0,0, 1,0,0, 16'h0040, 16'h0, 0,0,0,0);
        run(2'b10, 15'h3333, 15'h4444, 0, 0,0,0, 0,1,0, 16'h0080, 16'h0, 0,0,0,0);
        run(2'b00, 15'h5555, 15'h2AAA, 0, 0,0,0, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b00, 15'h0101, 15'h0202, 0, 1,0,1, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b00, 15'h0303, 15'h0404, 0, 1,0,0, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b00, 15'h0505, 15'h0606, 0, 0,1,1, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b00, 15'h0707, 15'h0808, 0, 0,1,0, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b00, 15'h0909, 15'h0A0A, 0, 1,1,0, 0,0,0, 16'h0, 16'h0, 0,0,0,0);
        run(2'b00, 15'h0B0B, 15'h0C0C, 0, 1,0,0, 0,1,0, 16'h0100, 16'h0, 0,0,0,0);
        // Directed: repeat loop back, loop exit, branch at loop end.
        run(2'b11, 0,0, 30'h1, 0,0,0, 0,0,0, 16'h0, 16'h0002, 16'h0050, exp_pc, 16'd5, 0);
        run(2'b11, 0,0, 30'h2, 0,0,0, 0,0,0, 16'h0, 16'h8002, 16'h0050, exp_pc, 16'd1, 0);
        run(2'b11, 0,0, 30'h3, 0,0,0, 0,0,0, 16'h0, 16'h0002, 16'h0050, exp_pc, 16'd0, 0);
        run(2'b01, 15'h1, 15'h2, 0, 0,0,0, 0,1,0, 16'h0200, 16'h0002, 16'h0050, exp_pc, 16'd3, 0);
        // Directed: breakpoint on fall-through, over a branch, over a loop exit.
        run(2'b11, 0,0, 30'h4, 0,0,0, 0,0,0, 16'h0, 16'h8004, 0, 0, 0, exp_pc + 16'd1);
        run(2'b11, 0,0, 30'h5, 0,0,0, 0,0,1, 16'h0333, 16'h0004, 0, 0, 0, 16'h0333);
        run(2'b11, 0,0, 30'h6, 0,0,0, 0,0,0, 16'h0, 16'h8006, 16'h0010, exp_pc, 16'd1, exp_pc + 16'd1);
        run(2'b11, 0,0, 30'h7, 0,0,0, 0,0,0, 16'h0, 16'h0006, 16'h0010, exp_pc, 16'd7, 16'h0010);
        run(2'b01, 15'h5, 15'h6, 0, 0,0,0, 0,0,0, 16'h0, 16'h0004, 0, 0, 0, 16'h1234);
        // Random steps.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] t, rs, re, cn, bp, ps;
            t  = 16'($urandom);
            rs = 16'($urandom);
            re = ($urandom % 2) ? exp_pc : 16'($urandom);
            cn = 16'($urandom % 4);
            ps = 16'($urandom) & 16'h8006;
            case ($urandom % 4)
                0: bp = exp_pc + 16'd1;
                1: bp = t;
                2: bp = rs;
                default: bp = 16'($urandom);
            endcase
            run(2'($urandom), 15'($urandom), 15'($urandom), 30'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
                t, ps, rs, re, cn, bp);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule